// File: doc/BRIEF.md
# Dual-Clock Link FIFO

This block buffers a stream of 16-bit words travelling over a point-to-point link between two tiles that run from unrelated clocks. The producer pushes at most one word per write-clock cycle and never waits for a per-word acknowledge. It keeps sending until the buffer raises a halt indication. The consumer pulls words on its own clock and stalls only when nothing is visible to it.

Each side keeps a binary pointer that is one bit wider than the address. The pointer is Gray-coded and carried to the other side through a synchronizer chain. The length of that chain is chosen at run time. The halt indication is raised while a reserve of free entries still remains, so words already in flight when halt is raised still find space.

A mode input turns the block into a plain single-clock FIFO. In that mode both ports share one clock and the synchronizer chains are taken out of the pointer path. Both configuration inputs may only change while both sides are held in reset.

Top module: `dcf_link_fifo`

## Requirements
- R1: The buffer holds 32 words of 16 bits. Words leave the read side in the order they entered the write side, including when the two clocks are unrelated.
- R2: While its own reset is held and in the cycle after it, each side shows its idle state: `rd_empty`=1, `rd_data`=0, `wr_full`=0, `wr_halt`=0, `wr_overflow`=0.
- R3: `wr_halt` is 1 exactly when the number of free entries seen by the writer is less than or equal to RESERVE (default 4). With the reader idle, halt is 0 after 27 words and 1 after 28.
- R4: `wr_full` is 1 when the writer sees 32 stored words. A write attempted while full drives `wr_stall`=1 during that cycle, stores nothing, and sets `wr_overflow`. `wr_overflow` stays set until the next write reset.
- R5: A read attempted while empty drives `rd_stall`=1, leaves `rd_data` unchanged and does not advance the read pointer. The next word written is the next word read.
- R6: When `cfg_sync_mode`=0, each crossing uses `cfg_sync_depth`+1 register stages (the setting 1 is the default of two stages). With both ports on one clock, `rd_empty` stays 1 after the first `cfg_sync_depth` read edges that follow the writing edge, and falls after edge `cfg_sync_depth`+1.
- R7: When `cfg_sync_mode`=1, the pointers are compared without synchronizer stages. `rd_empty` falls right after the clock edge that writes the first word.
- R8: A read returns the word in the register `rd_data` after the accepting read edge. While the buffer is neither empty nor full, a write and a read in every cycle proceed with no stall and the data stay in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Synchronous active-high reset of the write side |
| wr_en | input | 1 | Write request |
| wr_data | input | 16 | Word to store |
| wr_full | output | 1 | Writer sees all entries occupied |
| wr_halt | output | 1 | Producer must stop; reserve reached |
| wr_stall | output | 1 | Current write request is blocked by full |
| wr_overflow | output | 1 | Sticky: a write was dropped while full |
| rd_clk | input | 1 | Consumer clock (the write clock in single-clock mode) |
| rd_rst | input | 1 | Synchronous active-high reset of the read side |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Last word read (registered) |
| rd_empty | output | 1 | Reader sees no stored word |
| rd_stall | output | 1 | Current read request is blocked by empty |
| cfg_sync_mode | input | 1 | 1 selects single-clock operation with no synchronizers |
| cfg_sync_depth | input | 2 | Synchronizer stages minus one |

## Verification
The bench counts the read edges between a write and the fall of empty for every chain length and in bypass mode. A chain tapped at the wrong stage, or a bypass that still registers the pointer, shifts that edge by one or more cycles. It fills the buffer with the reader idle to find the exact word at which halt appears, and a threshold off by one moves it to word 27 or 29. It then pushes one word too many. A design that wraps the pointer would corrupt the oldest word, and one that forgets the sticky flag would clear overflow once the buffer drains. A read on an empty buffer followed by a write shows whether the read pointer slipped, because the reader would then skip the new word.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int MAX_SYNC   = 4;
    localparam int SYNC_SEL_W = $clog2(MAX_SYNC);
    localparam int CONV_W     = 32;

    typedef enum logic {
        LINK_ASYNC = 1'b0,
        LINK_SYNC  = 1'b1
    } link_mode_e;

    typedef struct packed {
        logic full;
        logic halt;
        logic stall;
        logic overflow;
    } wr_status_t;

    function automatic logic [CONV_W-1:0] bin_to_gray(input logic [CONV_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CONV_W-1:0] gray_to_bin(input logic [CONV_W-1:0] g);
        logic [CONV_W-1:0] b;
        b[CONV_W-1] = g[CONV_W-1];
        for (int i = CONV_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync
    import dcf_pkg::*;
#(
    parameter int W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bypass,
    input  logic [SYNC_SEL_W-1:0] sel,
    input  logic [W-1:0]          d,
    output logic [W-1:0]          q
);
    logic [W-1:0] chain [MAX_SYNC];

    for (genvar i = 0; i < MAX_SYNC; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = bypass ? d : chain[sel];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int RESERVE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W:0]   rptr_gray_s,
    output logic [ADDR_W:0]   wptr_gray,
    output logic [ADDR_W-1:0] waddr,
    output logic              accept,
    output wr_status_t        status
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] wbin, rbin_s, used, free_cnt, wbin_nxt;
    logic             overflow_q;

    assign rbin_s   = PTR_W'(gray_to_bin(CONV_W'(rptr_gray_s)));
    assign used     = wbin - rbin_s;
    assign free_cnt = PTR_W'(DEPTH) - used;
    assign status.full     = (used == PTR_W'(DEPTH));
    assign status.halt     = (free_cnt <= PTR_W'(RESERVE));
    assign status.stall    = en && status.full;
    assign status.overflow = overflow_q;
    assign accept   = en && !status.full;
    assign wbin_nxt = wbin + PTR_W'(1);
    assign waddr    = wbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin       <= '0;
            wptr_gray  <= '0;
            overflow_q <= 1'b0;
        end else begin
            if (accept) begin
                wbin      <= wbin_nxt;
                wptr_gray <= PTR_W'(bin_to_gray(CONV_W'(wbin_nxt)));
            end
            if (status.stall) overflow_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W:0]   wptr_gray_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W:0]   rptr_gray,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] data,
    output logic              empty,
    output logic              stall
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] rbin, wbin_s, rbin_nxt;
    logic             take;

    assign wbin_s   = PTR_W'(gray_to_bin(CONV_W'(wptr_gray_s)));
    assign empty    = (rbin == wbin_s);
    assign stall    = en && empty;
    assign take     = en && !empty;
    assign rbin_nxt = rbin + PTR_W'(1);
    assign raddr    = rbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin      <= '0;
            rptr_gray <= '0;
            data      <= '0;
        end else if (take) begin
            rbin      <= rbin_nxt;
            rptr_gray <= PTR_W'(bin_to_gray(CONV_W'(rbin_nxt)));
            data      <= mem_q;
        end
    end
endmodule

// File: rtl/dcf_link_fifo.sv
module dcf_link_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int RESERVE = 4
) (
    input  logic                  wr_clk,
    input  logic                  wr_rst,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  wr_full,
    output logic                  wr_halt,
    output logic                  wr_stall,
    output logic                  wr_overflow,
    input  logic                  rd_clk,
    input  logic                  rd_rst,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_empty,
    output logic                  rd_stall,
    input  logic                  cfg_sync_mode,
    input  logic [SYNC_SEL_W-1:0] cfg_sync_depth
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    link_mode_e        mode;
    logic              bypass;
    logic [PTR_W-1:0]  wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              accept;
    wr_status_t        wst;
    logic [DATA_W-1:0] mem [DEPTH];

    assign mode   = link_mode_e'(cfg_sync_mode);
    assign bypass = (mode == LINK_SYNC);

    dcf_wr_side #(.ADDR_W(ADDR_W), .RESERVE(RESERVE)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .en(wr_en), .rptr_gray_s(rptr_gray_s),
        .wptr_gray(wptr_gray), .waddr(waddr), .accept(accept), .status(wst)
    );

    dcf_sync #(.W(PTR_W)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .bypass(bypass), .sel(cfg_sync_depth),
        .d(rptr_gray), .q(rptr_gray_s)
    );

    dcf_sync #(.W(PTR_W)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .bypass(bypass), .sel(cfg_sync_depth),
        .d(wptr_gray), .q(wptr_gray_s)
    );

    always_ff @(posedge wr_clk) begin
        if (accept) mem[waddr] <= wr_data;
    end

    dcf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .en(rd_en), .wptr_gray_s(wptr_gray_s),
        .mem_q(mem[raddr]), .rptr_gray(rptr_gray), .raddr(raddr),
        .data(rd_data), .empty(rd_empty), .stall(rd_stall)
    );

    assign wr_full     = wst.full;
    assign wr_halt     = wst.halt;
    assign wr_stall    = wst.stall;
    assign wr_overflow = wst.overflow;
endmodule

// File: rtl/dcf_link_fifo_chk.sv
module dcf_link_fifo_chk
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_en,
    input logic              wr_full,
    input logic              wr_halt,
    input logic              wr_stall,
    input logic              wr_overflow,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_empty,
    input logic              rd_stall
);
    a_r2_wr_reset_idle: assert property (@(posedge wr_clk)
        wr_rst |=> (!wr_full && !wr_overflow && !wr_halt));

    a_r2_rd_reset_idle: assert property (@(posedge rd_clk)
        rd_rst |=> (rd_empty && rd_data == '0));

    a_r3_full_implies_halt: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_full |-> wr_halt);

    a_r4_stall_only_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_stall |-> (wr_full && wr_en));

    a_r4_overflow_sticky: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_overflow |=> wr_overflow);

    a_r4_overflow_cause: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(wr_overflow) |-> $past(wr_en && wr_full));

    a_r5_empty_read_holds: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> $stable(rd_data));

    a_r5_stall_only_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_stall |-> (rd_empty && rd_en));
endmodule

bind dcf_link_fifo dcf_link_fifo_chk #(.DATA_W(DATA_W)) chk (.*);

// File: tb/dcf_link_fifo_test.sv
module dcf_link_fifo_test;
    logic        wclk = 1'b0, rclk_a = 1'b0, same_clk = 1'b0;
    logic        rd_clk;
    logic        wr_rst = 1'b1, rd_rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_full, wr_halt, wr_stall, wr_overflow;
    logic [15:0] rd_data;
    logic        rd_empty, rd_stall;
    logic        cfg_sync_mode = 1'b0;
    logic [1:0]  cfg_sync_depth = 2'd1;
    int          checks = 0, failures = 0;

    always #10 wclk = ~wclk;
    always #13 rclk_a = ~rclk_a;
    assign rd_clk = same_clk ? wclk : rclk_a;

    dcf_link_fifo uut (
        .wr_clk(wclk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_halt(wr_halt), .wr_stall(wr_stall), .wr_overflow(wr_overflow),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_stall(rd_stall),
        .cfg_sync_mode(cfg_sync_mode), .cfg_sync_depth(cfg_sync_depth)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reset_all(input logic mode, input logic [1:0] depth, input logic shared);
        @(negedge wclk);
        wr_rst = 1'b1; rd_rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        cfg_sync_mode = mode; cfg_sync_depth = depth; same_clk = shared;
        repeat (6) @(negedge wclk);
        wr_rst = 1'b0; rd_rst = 1'b0;
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge wclk);
        wr_en = 1'b1; wr_data = v;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic pop(output logic [15:0] v);
        @(negedge rd_clk);
        while (rd_empty) @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset();
        reset_all(1'b0, 2'd1, 1'b0);
        @(negedge wclk);
        check(rd_empty == 1'b1, "R2 empty after reset", int'(rd_empty), 1);
        check(wr_full == 1'b0 && wr_halt == 1'b0, "R2 full/halt after reset",
              int'({wr_full, wr_halt}), 0);
        check(wr_overflow == 1'b0, "R2 overflow after reset", int'(wr_overflow), 0);
        check(rd_data == 16'h0, "R2 rd_data after reset", int'(rd_data), 0);
    endtask

    task automatic t_order();
        logic [15:0] v;
        reset_all(1'b0, 2'd1, 1'b0);
        for (int i = 0; i < 10; i++) push(16'hA000 + 16'(i * 7));
        for (int i = 0; i < 10; i++) begin
            pop(v);
            check(v == 16'hA000 + 16'(i * 7), "R1 async order", int'(v), int'(16'hA000 + 16'(i * 7)));
        end
        check(rd_empty == 1'b1, "R1 empty after drain", int'(rd_empty), 1);
    endtask

    task automatic t_empty_read();
        logic [15:0] v;
        logic [15:0] held;
        held = rd_data;
        @(negedge rd_clk);
        rd_en = 1'b1;
        #1;
        check(rd_stall == 1'b1, "R5 rd_stall on empty", int'(rd_stall), 1);
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(rd_data == held, "R5 rd_data held", int'(rd_data), int'(held));
        push(16'h7E57);
        pop(v);
        check(v == 16'h7E57, "R5 pointer not advanced", int'(v), int'(16'h7E57));
    endtask

    task automatic t_halt_full();
        logic [15:0] v;
        reset_all(1'b0, 2'd1, 1'b0);
        for (int i = 0; i < 27; i++) push(16'hC000 + 16'(i));
        check(wr_halt == 1'b0, "R3 no halt at 27 words", int'(wr_halt), 0);
        push(16'hC000 + 16'd27);
        check(wr_halt == 1'b1, "R3 halt at 28 words", int'(wr_halt), 1);
        check(wr_full == 1'b0, "R4 not full at 28", int'(wr_full), 0);
        for (int i = 28; i < 32; i++) push(16'hC000 + 16'(i));
        check(wr_full == 1'b1, "R4 full at 32", int'(wr_full), 1);
        check(wr_overflow == 1'b0, "R4 no overflow yet", int'(wr_overflow), 0);
        @(negedge wclk);
        wr_en = 1'b1; wr_data = 16'hDEAD;
        #1;
        check(wr_stall == 1'b1, "R4 wr_stall when full", int'(wr_stall), 1);
        @(negedge wclk);
        wr_en = 1'b0;
        check(wr_overflow == 1'b1, "R4 overflow set", int'(wr_overflow), 1);
        for (int i = 0; i < 32; i++) begin
            pop(v);
            check(v == 16'hC000 + 16'(i), "R4 stored words intact", int'(v), int'(16'hC000 + 16'(i)));
        end
        check(rd_empty == 1'b1, "R4 dropped word not stored", int'(rd_empty), 1);
        repeat (8) @(negedge wclk);
        check(wr_full == 1'b0 && wr_halt == 1'b0, "R3 halt released after drain",
              int'({wr_full, wr_halt}), 0);
        check(wr_overflow == 1'b1, "R4 overflow sticky", int'(wr_overflow), 1);
        t_empty_read();
    endtask

    task automatic t_depth(input logic [1:0] dv);
        int stages;
        logic [15:0] v;
        stages = int'(dv) + 1;
        reset_all(1'b0, dv, 1'b1);
        @(negedge wclk);
        wr_en = 1'b1; wr_data = 16'h1230 + 16'(dv);
        @(negedge wclk);
        wr_en = 1'b0;
        for (int j = 0; j <= stages; j++) begin
            check(rd_empty == (j < stages), $sformatf("R6 empty at edge %0d stages %0d", j, stages),
                  int'(rd_empty), int'(j < stages));
            @(negedge wclk);
        end
        pop(v);
        check(v == 16'h1230 + 16'(dv), "R6 word through chain", int'(v), int'(16'h1230 + 16'(dv)));
    endtask

    task automatic t_bypass();
        reset_all(1'b1, 2'd3, 1'b1);
        @(negedge wclk);
        check(rd_empty == 1'b1, "R7 empty before write", int'(rd_empty), 1);
        wr_en = 1'b1; wr_data = 16'hB001;
        @(negedge wclk);
        wr_en = 1'b0;
        check(rd_empty == 1'b0, "R7 visible after one edge", int'(rd_empty), 0);
    endtask

    task automatic t_stream();
        reset_all(1'b1, 2'd1, 1'b1);
        for (int i = 0; i < 3; i++) push(16'h5000 + 16'(i));
        for (int k = 0; k < 16; k++) begin
            @(negedge wclk);
            if (k > 0)
                check(rd_data == 16'h5000 + 16'(k - 1), "R8 stream data",
                      int'(rd_data), int'(16'h5000 + 16'(k - 1)));
            wr_en = 1'b1; rd_en = 1'b1; wr_data = 16'h5003 + 16'(k);
            #1;
            check(!wr_stall && !rd_stall, "R8 no stall when partial",
                  int'({wr_stall, rd_stall}), 0);
        end
        @(negedge wclk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_data == 16'h500F, "R8 last stream word", int'(rd_data), int'(16'h500F));
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_halt_full();
        for (int d = 0; d < 4; d++) t_depth(2'(d));
        t_bypass();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule